// File: doc/BRIEF.md
# Descriptor-Chain Multi-Lane SPI Sequencer

This block walks a linked chain of 32-bit descriptors held in a small internal register file. Each descriptor drives one phase of an SPI transaction on a 1-, 2- or 4-lane bus: sending bytes taken from a transmit FIFO, capturing bytes into a receive FIFO, or producing dummy clocks with every lane released. A start pulse names the first entry. Each descriptor's next field names its successor, and a descriptor flagged as final ends the chain.

The sequencer does not toggle a clock itself. It asks a serial engine for shift cycles, one lane-width of bits per cycle, and it stalls when data is missing: when the transmit FIFO is empty, or when the received byte has not yet been taken. It drives chip select and reports whether it is busy, which entry it is on, whether the chain completed, and whether a descriptor was malformed. A stop request ends the run cleanly at the next unit boundary.

Top module: `dsq_seq`

## Requirements
- R1: After reset the block is idle. `cs_n` is 1. `done`, `prog_err`, `shift_go`, `tx_ready`, `rx_valid` and `lanes_oe` are all 0.
- R2: A `start` pulse in idle runs the descriptor at `start_idx`. Descriptor bits [15:12] name the next entry, and bit 6 set marks the final entry. While running, `cur_idx` shows the entry in progress, and it keeps the final entry's index after the run ends.
- R3: Bits [1:0] select the lanes: 00 is one lane, 01 is two lanes, 1x is four lanes. Each byte is shifted most significant part first. On one lane, data goes out on lane 0 and comes in on lane 1. On two lanes it uses lanes 1:0, and on four lanes it uses lanes 3:0. While transmitting, `lanes_oe` is 0001, 0011 or 1111 for those three widths.
- R4: Bits [11:10] give the unit size: 00 bit, 01 one byte, 10 four bytes, 11 sixteen bytes. Bits [30:16] give the unit count. A byte-unit descriptor makes count × size × 8 / lanes shifts.
- R5: Bits [3:2] select the transmit mode (00 off, 01 data) and bit 4 enables receive. With transmit off and receive off, the descriptor produces dummy clocks with `lanes_oe` = 0. With bit units, a dummy phase makes count / lanes shifts, rounded down.
- R6: In transmit mode, each byte is accepted through a `tx_valid`/`tx_ready` handshake. `tx_ready` drops for the cycle after an acceptance. No shift occurs while no byte is held.
- R7: In receive mode, each assembled byte is offered on `rx_valid`/`rx_data` and held stable until `rx_ready`. Shifting pauses while a byte is waiting.
- R8: `done` is set when the final descriptor completes or when a stop takes effect. It stays set until `sts_clr[0]` is 1. If a set and a clear fall in the same cycle, the set wins.
- R9: Bit 5 (close) releases `cs_n` when that descriptor completes. A final descriptor without close leaves `cs_n` at 0 after the run.
- R10: Loading a descriptor with transmit mode 1x, with transmit data and receive both enabled, with bit units plus data, or with any of bits [9:7] or [31] set, causes no shifts. Instead it sets `prog_err`, releases `cs_n` and returns to idle without setting `done`. `prog_err` stays set until `sts_clr[1]` is 1.
- R11: A `stop` pulse while active ends the run at the next unit boundary, with `done` set and `cs_n` released.
- R12: `start` while active and `stop` while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_wr_en | input | 1 | Descriptor write strobe |
| desc_wr_idx | input | 4 | Descriptor entry to write |
| desc_wr_data | input | 32 | Descriptor contents |
| start | input | 1 | Begin a chain (idle only) |
| start_idx | input | 4 | First descriptor of the chain |
| stop | input | 1 | End at next unit boundary |
| sts_clr | input | 2 | Write-one-to-clear: bit0 done, bit1 prog_err |
| tx_valid | input | 1 | Transmit FIFO has a byte |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_ready | output | 1 | Sequencer takes the transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Receive FIFO accepts the byte |
| shift_rdy | input | 1 | Serial engine can perform a shift this cycle |
| shift_go | output | 1 | One shift performed this cycle |
| lanes_out | output | 4 | Lane data for this shift |
| lanes_oe | output | 4 | Lane output enables |
| lanes_in | input | 4 | Lane data sampled on this shift |
| cs_n | output | 1 | Chip select, active low |
| active | output | 1 | Chain in progress |
| done | output | 1 | Sticky completion status |
| prog_err | output | 1 | Sticky malformed-descriptor status |
| cur_idx | output | 4 | Current or last executed descriptor |

## Verification
Two events can coincide in one cycle: the final descriptor setting `done`, and software clearing it. The bench holds `sts_clr[0]` high across a zero-count final descriptor. It expects `done` to read 1 in the first idle cycle and 0 one cycle later. A second overlap is a stop request that lands mid-unit while bytes keep flowing. The bench expects the run to end exactly on the following unit boundary, judged by the number of shifts and the number of bytes accepted.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    localparam int DESC_W      = 32;
    localparam int F_TXM_LSB   = 2;
    localparam int F_RX_EN     = 4;
    localparam int F_CLOSE     = 5;
    localparam int F_LAST      = 6;
    localparam int F_UNIT_LSB  = 10;
    localparam int F_NEXT_LSB  = 12;
    localparam int F_CNT_LSB   = 16;

    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LOAD = 2'd1, ST_RUN = 2'd2} dsq_state_e;
    typedef enum logic [1:0] {PH_DUMMY = 2'd0, PH_TX = 2'd1, PH_RX = 2'd2} dsq_phase_e;
    typedef enum logic [1:0] {UNIT_BIT = 2'd0, UNIT_B1 = 2'd1, UNIT_B4 = 2'd2, UNIT_B16 = 2'd3} dsq_unit_e;

    // log2 of lane count: 00 -> 0, 01 -> 1, 1x -> 2
    function automatic logic [1:0] lane_log(input logic [1:0] f);
        return f[1] ? 2'd2 : {1'b0, f[0]};
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] ls);
        return (ls == 2'd0) ? 4'h1 : (ls == 2'd1) ? 4'h3 : 4'hF;
    endfunction

endpackage

// File: rtl/dsq_desc_file.sv
module dsq_desc_file #(
    parameter int NUM_DESC = 16,
    parameter int WIDTH    = 32,
    localparam int IW      = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] ent_q [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
        logic [WIDTH-1:0] ent_d;
        always_comb ent_d = (wr_en && wr_idx == IW'(g)) ? wr_data : ent_q[g];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d;
        end
    end

    assign rd_data = ent_q[rd_idx];
endmodule

// File: rtl/dsq_lane_shifter.sv
module dsq_lane_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       shift,
    input  logic [1:0] ls,
    input  logic [3:0] lanes_in,
    output logic [3:0] lanes_out,
    output logic [7:0] shifted
);
    logic [7:0] sreg_d, sreg_q;

    always_comb begin
        unique case (ls)
            2'd0: begin
                shifted   = {sreg_q[6:0], lanes_in[1]};
                lanes_out = {3'b000, sreg_q[7]};
            end
            2'd1: begin
                shifted   = {sreg_q[5:0], lanes_in[1:0]};
                lanes_out = {2'b00, sreg_q[7:6]};
            end
            default: begin
                shifted   = {sreg_q[3:0], lanes_in};
                lanes_out = sreg_q[7:4];
            end
        endcase
        sreg_d = load ? load_byte : (shift ? shifted : sreg_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end
endmodule

// File: rtl/dsq_seq.sv
module dsq_seq
    import dsq_pkg::*;
#(
    parameter int NUM_DESC = 16,
    parameter int CNT_W    = 15,
    localparam int IW      = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_wr_en,
    input  logic [IW-1:0]     desc_wr_idx,
    input  logic [DESC_W-1:0] desc_wr_data,
    input  logic              start,
    input  logic [IW-1:0]     start_idx,
    input  logic              stop,
    input  logic [1:0]        sts_clr,
    input  logic              tx_valid,
    input  logic [7:0]        tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    input  logic              rx_ready,
    input  logic              shift_rdy,
    output logic              shift_go,
    output logic [3:0]        lanes_out,
    output logic [3:0]        lanes_oe,
    input  logic [3:0]        lanes_in,
    output logic              cs_n,
    output logic              active,
    output logic              done,
    output logic              prog_err,
    output logic [IW-1:0]     cur_idx
);
    typedef struct packed {
        dsq_state_e       st;
        logic [IW-1:0]    idx;
        logic [IW-1:0]    nxt;
        dsq_phase_e       ph;
        logic [1:0]       ls;
        logic             last;
        logic             close;
        logic [CNT_W-1:0] units;
        logic [7:0]       spu;
        logic [7:0]       shl;
        logic [2:0]       bcnt;
        logic             have;
        logic             rxf;
        logic [7:0]       rxb;
        logic             stop;
        logic             done;
        logic             perr;
        logic             cs;
    } seq_t;

    seq_t r_d, r_q;
    logic [DESC_W-1:0] dsc;
    logic [7:0]        shifted;
    logic              tx_take, shift_c, tx_rdy_c;

    dsq_desc_file #(.NUM_DESC(NUM_DESC), .WIDTH(DESC_W)) u_file (
        .clk(clk), .rst_n(rst_n), .wr_en(desc_wr_en), .wr_idx(desc_wr_idx),
        .wr_data(desc_wr_data), .rd_idx(r_q.idx), .rd_data(dsc)
    );

    dsq_lane_shifter u_shf (
        .clk(clk), .rst_n(rst_n), .load(tx_take), .load_byte(tx_data),
        .shift(shift_c), .ls(r_q.ls), .lanes_in(lanes_in),
        .lanes_out(lanes_out), .shifted(shifted)
    );

    always_comb begin
        logic [1:0]       txm, unit, ls_new;
        logic             rxe, bad, at_bnd, halt, feed_ok;
        logic [2:0]       szl;
        logic [CNT_W-1:0] cnt;

        r_d    = r_q;
        txm    = dsc[F_TXM_LSB +: 2];
        rxe    = dsc[F_RX_EN];
        unit   = dsc[F_UNIT_LSB +: 2];
        cnt    = dsc[F_CNT_LSB +: CNT_W];
        ls_new = lane_log(dsc[1:0]);
        szl    = (unit == UNIT_B1) ? 3'd0 : (unit == UNIT_B4) ? 3'd2 : 3'd4;
        bad    = txm[1] || (txm[0] && rxe) || ((unit == UNIT_BIT) && (txm[0] || rxe))
              || (dsc[9:7] != 3'b000) || ((dsc >> (F_CNT_LSB + CNT_W)) != '0);

        at_bnd  = (r_q.shl == r_q.spu);
        halt    = r_q.stop && at_bnd;
        unique case (r_q.ph)
            PH_TX:   feed_ok = r_q.have;
            PH_RX:   feed_ok = !r_q.rxf;
            default: feed_ok = 1'b1;
        endcase
        tx_rdy_c = (r_q.st == ST_RUN) && (r_q.ph == PH_TX) && !r_q.have
                && (r_q.units != '0) && !halt;
        tx_take  = tx_rdy_c && tx_valid;
        shift_c  = (r_q.st == ST_RUN) && (r_q.units != '0) && !halt && feed_ok && shift_rdy;

        if (sts_clr[0]) r_d.done = 1'b0;
        if (sts_clr[1]) r_d.perr = 1'b0;
        if (r_q.rxf && rx_ready) r_d.rxf = 1'b0;
        if (stop && r_q.st != ST_IDLE) r_d.stop = 1'b1;
        if (tx_take) r_d.have = 1'b1;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.idx  = start_idx;
                    r_d.stop = 1'b0;
                    r_d.st   = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (r_q.stop) begin
                    r_d.done = 1'b1;
                    r_d.cs   = 1'b0;
                    r_d.st   = ST_IDLE;
                end else if (bad) begin
                    r_d.perr = 1'b1;
                    r_d.cs   = 1'b0;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.ph    = txm[0] ? PH_TX : (rxe ? PH_RX : PH_DUMMY);
                    r_d.ls    = ls_new;
                    r_d.last  = dsc[F_LAST];
                    r_d.close = dsc[F_CLOSE];
                    r_d.nxt   = dsc[F_NEXT_LSB +: IW];
                    r_d.units = (unit == UNIT_BIT) ? (cnt >> ls_new) : cnt;
                    r_d.spu   = (unit == UNIT_BIT) ? 8'd1 : ((8'd8 << szl) >> ls_new);
                    r_d.shl   = r_d.spu;
                    r_d.bcnt  = 3'd0;
                    r_d.have  = 1'b0;
                    r_d.cs    = 1'b1;
                    r_d.st    = ST_RUN;
                end
            end
            ST_RUN: begin
                if (halt) begin
                    r_d.done = 1'b1;
                    r_d.cs   = 1'b0;
                    r_d.st   = ST_IDLE;
                end else if (r_q.units == '0) begin
                    if (r_q.close) r_d.cs = 1'b0;
                    if (r_q.last) begin
                        r_d.done = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.nxt;
                        r_d.st  = ST_LOAD;
                    end
                end else if (shift_c) begin
                    if (r_q.bcnt == (3'd7 >> r_q.ls)) begin
                        r_d.bcnt = 3'd0;
                        r_d.have = 1'b0;
                        if (r_q.ph == PH_RX) begin
                            r_d.rxf = 1'b1;
                            r_d.rxb = shifted;
                        end
                    end else begin
                        r_d.bcnt = r_q.bcnt + 3'd1;
                    end
                    if (r_q.shl == 8'd1) begin
                        r_d.shl   = r_q.spu;
                        r_d.units = r_q.units - 1'b1;
                    end else begin
                        r_d.shl = r_q.shl - 8'd1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_ready = tx_rdy_c;
    assign shift_go = shift_c;
    assign rx_valid = r_q.rxf;
    assign rx_data  = r_q.rxb;
    assign lanes_oe = (r_q.st == ST_RUN && r_q.ph == PH_TX) ? lane_mask(r_q.ls) : 4'h0;
    assign cs_n     = !r_q.cs;
    assign active   = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign prog_err = r_q.perr;
    assign cur_idx  = r_q.idx;
endmodule

// File: rtl/dsq_seq_chk.sv
module dsq_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sts_clr,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic       rx_ready,
    input logic [7:0] rx_data,
    input logic       shift_rdy,
    input logic       shift_go,
    input logic [3:0] lanes_oe,
    input logic       cs_n,
    input logic       active,
    input logic       done,
    input logic       prog_err
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!shift_go && !tx_ready && lanes_oe == 4'h0));

    assert_oe_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lanes_oe != 4'h0 |-> (!cs_n && (lanes_oe == 4'h1 || lanes_oe == 4'h3 || lanes_oe == 4'hF)));

    assert_shift_needs_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |-> (shift_rdy && active));

    assert_tx_one_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sts_clr[0]) |=> done);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !sts_clr[1]) |=> prog_err);

    assert_err_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_err) |-> (cs_n && !active));
endmodule

bind dsq_seq dsq_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sts_clr(sts_clr), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .shift_rdy(shift_rdy), .shift_go(shift_go),
    .lanes_oe(lanes_oe), .cs_n(cs_n), .active(active), .done(done),
    .prog_err(prog_err)
);

// File: tb/test_dsq_seq.sv
`timescale 1ns/1ps
module test_dsq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_wr_en = 1'b0;
    logic [3:0]  desc_wr_idx = '0;
    logic [31:0] desc_wr_data = '0;
    logic        start = 1'b0;
    logic [3:0]  start_idx = '0;
    logic        stop = 1'b0;
    logic [1:0]  sts_clr = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready, rx_valid, rx_ready = 1'b1;
    logic [7:0]  rx_data;
    logic        shift_rdy = 1'b1, shift_go;
    logic [3:0]  lanes_out, lanes_oe, lanes_in = '0;
    logic        cs_n, active, done, prog_err;
    logic [3:0]  cur_idx;

    always #4 clk = ~clk;

    dsq_seq i_dsq_seq (.*);

    int nchecks = 0, nfail = 0, nshift = 0, ntx = 0, cyc = 0;
    bit throttle = 1'b0, pop_in = 1'b0, pop_tx = 1'b0;
    logic [3:0] eo_q[$], ed_q[$], in_q[$];
    logic [7:0] txq[$], exp_rx[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] msk(int ls);
        return (ls == 0) ? 4'h1 : (ls == 1) ? 4'h3 : 4'hF;
    endfunction

    function automatic logic [31:0] mk(int ln, int txm, int rxe, int cls, int lst,
                                       int unit, int nx, int cnt);
        logic [31:0] v = '0;
        v[1:0] = ln[1:0]; v[3:2] = txm[1:0]; v[4] = rxe[0]; v[5] = cls[0];
        v[6] = lst[0]; v[11:10] = unit[1:0]; v[15:12] = nx[3:0]; v[30:16] = cnt[14:0];
        return v;
    endfunction

    task automatic push_tx(input logic [7:0] b, input int ls);
        int w = 1 << ls;
        txq.push_back(b);
        for (int i = 0; i < (8 >> ls); i++) begin
            eo_q.push_back(msk(ls));
            ed_q.push_back(4'((b >> (8 - w * (i + 1))) & ((1 << w) - 1)));
        end
    endtask

    task automatic push_rx(input logic [7:0] b, input int ls);
        int w = 1 << ls;
        exp_rx.push_back(b);
        for (int i = 0; i < (8 >> ls); i++) begin
            logic [3:0] c = 4'((b >> (8 - w * (i + 1))) & ((1 << w) - 1));
            in_q.push_back(ls == 0 ? (c << 1) : c);
            eo_q.push_back(4'h0);
            ed_q.push_back(4'h0);
        end
    endtask

    task automatic push_dummy(input int n);
        for (int i = 0; i < n; i++) begin
            eo_q.push_back(4'h0);
            ed_q.push_back(4'h0);
        end
    endtask

    // reference model: expected lane activity, compared on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (shift_go) begin
                nshift++;
                if (eo_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected shift", 1, 0);
                end else begin
                    check(lanes_oe == eo_q[0], "R3", "lane enable", lanes_oe, eo_q[0]);
                    check((lanes_out & eo_q[0]) == (ed_q[0] & eo_q[0]), "R3", "lane data",
                          lanes_out & eo_q[0], ed_q[0] & eo_q[0]);
                    void'(eo_q.pop_front());
                    void'(ed_q.pop_front());
                end
                pop_in = 1'b1;
            end
            if (tx_valid && tx_ready) pop_tx = 1'b1;
            if (rx_valid && rx_ready) begin
                if (exp_rx.size() == 0) check(1'b0, "R7", "unexpected rx byte", rx_data, 0);
                else begin
                    check(rx_data == exp_rx[0], "R7", "rx byte", rx_data, exp_rx[0]);
                    void'(exp_rx.pop_front());
                end
            end
        end
    end

    always @(posedge clk) begin
        #1;
        cyc++;
        if (pop_in && in_q.size() != 0) void'(in_q.pop_front());
        if (pop_tx && txq.size() != 0) begin
            void'(txq.pop_front());
            ntx++;
        end
        pop_in = 1'b0;
        pop_tx = 1'b0;
        lanes_in  = (in_q.size() != 0) ? in_q[0] : 4'h0;
        tx_valid  = (txq.size() != 0);
        tx_data   = (txq.size() != 0) ? txq[0] : 8'h00;
        shift_rdy = throttle ? cyc[0] : 1'b1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr_desc(input int idx, input logic [31:0] v);
        desc_wr_en = 1'b1; desc_wr_idx = 4'(idx); desc_wr_data = v;
        tick(1);
        desc_wr_en = 1'b0;
    endtask

    task automatic go(input int idx);
        start = 1'b1; start_idx = 4'(idx);
        tick(1);
        start = 1'b0;
    endtask

    task automatic clr_all();
        sts_clr = 2'b11;
        tick(1);
        sts_clr = 2'b00;
    endtask

    task automatic wait_idle(input string req);
        int i;
        for (i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!active) break;
        end
        if (i == 20000) check(1'b0, req, "run never ended", 1, 0);
        tick(1);
    endtask

    initial begin
        int base, tbase;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!active && cs_n && !done && !prog_err, "R1", "idle after reset",
              {active, cs_n, done, prog_err}, 4'b0100);
        check(!shift_go && !tx_ready && !rx_valid && lanes_oe == 0, "R1", "quiet after reset",
              {shift_go, tx_ready, rx_valid, lanes_oe}, 0);
        tick(1);

        // single-lane transmit, FIFO empty at first
        wr_desc(0, mk(0, 1, 0, 1, 1, 1, 0, 2));
        base = nshift;
        go(0);
        tick(10);
        check(nshift == base, "R6", "no shift while tx fifo empty", nshift - base, 0);
        check(!cs_n && active, "R9", "cs asserted while running", cs_n, 0);
        push_tx(8'hA5, 0); push_tx(8'h3C, 0);
        wait_idle("R2");
        check(nshift - base == 16, "R4", "single byte shifts", nshift - base, 16);
        check(done && cs_n, "R9", "done and cs released after close", {done, cs_n}, 2'b11);
        check(cur_idx == 0, "R2", "cur_idx after run", cur_idx, 0);
        check(eo_q.size() == 0, "R3", "all tx shifts seen", eo_q.size(), 0);
        clr_all();

        // quad then dual transmit chain, no close at end
        wr_desc(3, mk(2, 1, 0, 0, 0, 2, 7, 1));
        wr_desc(7, mk(1, 1, 0, 0, 1, 1, 0, 1));
        push_tx(8'h12, 2); push_tx(8'h34, 2); push_tx(8'h56, 2); push_tx(8'h78, 2);
        push_tx(8'hE1, 1);
        base = nshift;
        go(3);
        wait_idle("R2");
        check(nshift - base == 12, "R4", "4-byte quad + 1-byte dual shifts", nshift - base, 12);
        check(cur_idx == 7, "R2", "chain followed next field", cur_idx, 7);
        check(done && !cs_n, "R9", "cs held without close", {done, cs_n}, 2'b10);
        sts_clr = 2'b01; tick(1); sts_clr = 2'b00;
        check(!done && !cs_n, "R8", "done cleared by write-one", {done, cs_n}, 0);

        // malformed descriptors
        wr_desc(6, mk(0, 1, 1, 1, 1, 1, 0, 1));
        base = nshift;
        go(6);
        tick(4);
        check(prog_err && !active && cs_n, "R10", "tx+rx flagged, cs released",
              {prog_err, active, cs_n}, 3'b101);
        check(!done && nshift == base, "R10", "no done, no shifts", {done, 8'(nshift - base)}, 0);
        tick(3);
        check(prog_err, "R10", "prog_err sticky", prog_err, 1);
        sts_clr = 2'b10; tick(1); sts_clr = 2'b00;
        check(!prog_err, "R10", "prog_err cleared", prog_err, 0);
        wr_desc(6, mk(0, 1, 0, 1, 1, 0, 0, 8));
        go(6);
        tick(4);
        check(prog_err && nshift == base, "R10", "bit units with data flagged", prog_err, 1);
        wr_desc(6, mk(0, 0, 0, 1, 1, 1, 0, 1) | 32'h0000_0080);
        clr_all();
        go(6);
        tick(4);
        check(prog_err && nshift == base, "R10", "reserved bit flagged", prog_err, 1);
        clr_all();

        // quad receive with stall, then single-lane receive
        wr_desc(1, mk(2, 0, 1, 1, 1, 1, 0, 3));
        push_rx(8'h5A, 2); push_rx(8'hC3, 2); push_rx(8'h81, 2);
        rx_ready = 1'b0;
        base = nshift;
        go(1);
        tick(30);
        check(nshift - base == 2, "R7", "shifting paused while byte waits", nshift - base, 2);
        check(rx_valid && rx_data == 8'h5A, "R7", "byte held", rx_data, 8'h5A);
        rx_ready = 1'b1;
        wait_idle("R7");
        tick(3);
        check(exp_rx.size() == 0 && done, "R7", "all quad bytes received", exp_rx.size(), 0);
        clr_all();
        wr_desc(8, mk(0, 0, 1, 1, 1, 1, 0, 1));
        push_rx(8'h96, 0);
        go(8);
        wait_idle("R3");
        tick(3);
        check(exp_rx.size() == 0, "R3", "single-lane byte on lane 1", exp_rx.size(), 0);
        clr_all();

        // dummy clocks: dual bits then quad 16-byte unit, throttled engine
        wr_desc(4, mk(1, 0, 0, 0, 0, 0, 5, 9));
        wr_desc(5, mk(2, 0, 0, 1, 1, 3, 0, 1));
        push_dummy(36);
        throttle = 1'b1;
        base = nshift;
        go(4);
        wait_idle("R5");
        throttle = 1'b0;
        check(nshift - base == 36, "R5", "dummy shift count", nshift - base, 36);
        check(done && cur_idx == 5 && cs_n, "R4", "16-byte unit chain end", cur_idx, 5);
        clr_all();

        // stop mid-unit: 3 units of 4 bytes, single lane
        wr_desc(2, mk(0, 1, 0, 0, 1, 2, 0, 3));
        for (int i = 0; i < 12; i++) push_tx(8'(8'h40 + i), 0);
        base = nshift; tbase = ntx;
        go(2);
        while (nshift - base < 40) @(negedge clk);
        tick(1);
        stop = 1'b1; tick(1); stop = 1'b0;
        wait_idle("R11");
        check(nshift - base == 64, "R11", "ended on unit boundary", nshift - base, 64);
        check(ntx - tbase == 8, "R11", "bytes taken before stop", ntx - tbase, 8);
        check(done && cs_n, "R11", "done and cs released", {done, cs_n}, 2'b11);
        txq.delete(); eo_q.delete(); ed_q.delete();
        tick(2);
        clr_all();

        // done set and clear in the same cycle
        wr_desc(9, mk(0, 0, 0, 1, 1, 1, 0, 0));
        sts_clr = 2'b01;
        go(9);
        wait_idle("R8");
        sts_clr = 2'b00;
        tick(1);
        go(9);
        sts_clr = 2'b01;
        begin
            int k;
            for (k = 0; k < 50; k++) begin
                @(negedge clk);
                if (!active) break;
            end
            check(done, "R8", "set wins over same-cycle clear", done, 1);
            @(negedge clk);
            check(!done, "R8", "clear takes effect next cycle", done, 0);
        end
        tick(1);
        sts_clr = 2'b00;

        // start while active, stop while idle
        wr_desc(10, mk(0, 0, 0, 1, 1, 1, 0, 4));
        push_dummy(32);
        base = nshift;
        go(10);
        tick(5);
        go(9);
        wait_idle("R12");
        check(cur_idx == 10 && nshift - base == 32, "R12", "start while active ignored",
              cur_idx, 10);
        clr_all();
        stop = 1'b1; tick(1); stop = 1'b0;
        wr_desc(11, mk(0, 0, 0, 1, 1, 0, 0, 4));
        push_dummy(4);
        base = nshift;
        go(11);
        wait_idle("R12");
        check(nshift - base == 4 && done, "R12", "stop while idle ignored", nshift - base, 4);

        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchecks++;
        nfail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    end
endmodule